// File: doc/BRIEF.md
# Programmable Four-Window Bank Mapper

This block reproduces cartridge bank-switching schemes without any logic tied to one scheme. It holds four window descriptors. Each descriptor says where in the 16-bit CPU space a window sits and how large it is. It also says which CPU write addresses act as that window's page register, how many pages exist, whether the window also answers 32 KB away, whether it maps flash or RAM, and whether CPU writes may pass through to the memory. A separate block register picks the 64 KB block of the physical space that all windows are offset from.

On every CPU cycle the block combinationally resolves the address to at most one window. It drives a select, a media flag, a memory write enable and a 23-bit physical address. On a CPU write whose high address byte matches a window's page-register decode, that window's page number is loaded from the write data at the clock edge. Configuration bytes are loaded through a small indexed write port.

Top module: `bankmap_top`

## Requirements
- R1: After reset, window 0 holds register mask F8h, register address 50h, page 00h, mode 85h, page mask 03h and base 40h. Windows 1 to 3 and the block register hold 00h. A configuration write with `cfg_idx` = 6*w+f loads field f of window w, where f is 0 register mask, 1 register address, 2 page, 3 mode, 4 page mask and 5 base.
- R2: A CPU write loads a window's page with `cpu_wdata` when mode bit 7 is set and (`cpu_addr[15:8]` AND register mask) equals the register address. Other CPU writes leave the page unchanged.
- R3: Mode bits 2..0 give the window size: 3 is 4 KB, 4 is 8 KB, 5 is 16 KB, 6 is 32 KB and 7 is 64 KB. The window covers base*256 up to base*256+size-1, modulo 64 KB.
- R4: A window with mode bit 3 set, or a size code of 0, 1 or 2, never matches.
- R5: With mode bit 6 clear, the window also matches an address whose bit 15 is inverted. With bit 6 set, it does not.
- R6: `mem_addr` = (block*65536 + (page AND page mask)*size + (cpu_addr - base*256) mod size) mod 2^23.
- R7: `mem_ram` equals mode bit 5 of the matching window (1 RAM, 0 flash).
- R8: `mem_we` is 1 only on a CPU write to a matched window whose mode bit 4 is set.
- R9: A CPU write that hits the page register of any window with mode bit 4 clear never raises `mem_we`. A hit on a page register whose window has bit 4 set does not block the write.
- R10: When windows overlap, the lowest-numbered matching window wins. With no match, `mem_sel`, `mem_ram`, `mem_we` and `mem_addr` are all 0.
- R11: `cfg_idx` 24 loads the 7-bit block register, which adds block*65536 to the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 5 | Configuration byte index (6*window+field, 24 = block) |
| cfg_data | input | 8 | Configuration byte value |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| mem_sel | output | 1 | Some window matches the address |
| mem_ram | output | 1 | Matched window targets RAM |
| mem_we | output | 1 | Write permitted to memory |
| mem_addr | output | 23 | Physical address |

## Verification
The bench builds the block with its default parameters: four windows and a 23-bit physical space with a 7-bit block register. Four windows make priority across more than two overlapping descriptors reachable. They also let one window's page register sit inside another's area, which is the case R9 depends on. The full block range lets random block values exercise the truncation at the top of the physical space.

// File: rtl/bankmap_pkg.sv
`timescale 1ns/1ps
package bankmap_pkg;
  localparam int CFG_FIELDS = 6;
  localparam int F_RMASK = 0;
  localparam int F_RADDR = 1;
  localparam int F_PAGE  = 2;
  localparam int F_MODE  = 3;
  localparam int F_PMASK = 4;
  localparam int F_BASE  = 5;

  // mode byte bit positions
  localparam int M_PREG  = 7;
  localparam int M_NOMIR = 6;
  localparam int M_RAM   = 5;
  localparam int M_WEN   = 4;
  localparam int M_OFF   = 3;

  typedef struct packed {
    logic [7:0] rmask;
    logic [7:0] raddr;
    logic [7:0] page;
    logic [7:0] mode;
    logic [7:0] pmask;
    logic [7:0] base;
  } bank_cfg_t;

  // log2 of window bytes; 0 for codes that disable the window
  function automatic logic [4:0] win_log2(input logic [2:0] code);
    return (code >= 3'd3) ? (5'(code) + 5'd9) : 5'd0;
  endfunction

  function automatic logic win_ok(input logic [7:0] mode);
    return !mode[M_OFF] && (mode[2:0] >= 3'd3);
  endfunction

  function automatic logic [16:0] win_size(input logic [2:0] code);
    return 17'd1 << win_log2(code);
  endfunction

  function automatic logic [15:0] rel_addr(input logic [15:0] a, input logic [7:0] base);
    return a - {base, 8'h00};
  endfunction

  function automatic logic covers(input logic [15:0] a, input logic [7:0] base,
                                  input logic [7:0] mode);
    logic [16:0] sz;
    logic direct, mirror;
    sz     = win_size(mode[2:0]);
    direct = {1'b0, rel_addr(a, base)} < sz;
    mirror = !mode[M_NOMIR] && ({1'b0, rel_addr(a ^ 16'h8000, base)} < sz);
    return win_ok(mode) && (direct || mirror);
  endfunction

  function automatic logic [31:0] phys_calc(input logic [15:0] a, input bank_cfg_t c,
                                            input logic [7:0] blk);
    logic [15:0] off_mask;
    logic [31:0] pg;
    off_mask = 16'(win_size(c.mode[2:0]) - 17'd1);
    pg       = 32'(c.page & c.pmask) << win_log2(c.mode[2:0]);
    return ({24'd0, blk} << 16) + pg + {16'd0, rel_addr(a, c.base) & off_mask};
  endfunction
endpackage

// File: rtl/bankmap_regs.sv
`timescale 1ns/1ps
module bankmap_regs
  import bankmap_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int BLK_W  = 7,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_data,
  input  logic              cpu_wr,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        cpu_wdata,
  output bank_cfg_t         cfg [NBANKS],
  output logic [NBANKS-1:0] preg_hit,
  output logic [BLK_W-1:0]  blk
);
  localparam int BLK_IDX = NBANKS * CFG_FIELDS;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam int BASE_IDX = b * CFG_FIELDS;
    localparam bank_cfg_t RST_VAL = (b == 0) ? bank_cfg_t'(48'hF8_50_00_85_03_40)
                                             : bank_cfg_t'(48'h0);
    bank_cfg_t             r;
    logic [CFG_FIELDS-1:0] fw;

    always_comb begin
      for (int f = 0; f < CFG_FIELDS; f++)
        fw[f] = cfg_we && (int'(cfg_idx) == BASE_IDX + f);
    end

    assign preg_hit[b] = cpu_wr && r.mode[M_PREG] && ((addr_hi & r.rmask) == r.raddr);
    assign cfg[b] = r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= RST_VAL;
      end else begin
        if (fw[F_RMASK]) r.rmask <= cfg_data;
        if (fw[F_RADDR]) r.raddr <= cfg_data;
        if (fw[F_MODE])  r.mode  <= cfg_data;
        if (fw[F_PMASK]) r.pmask <= cfg_data;
        if (fw[F_BASE])  r.base  <= cfg_data;
        if (fw[F_PAGE])        r.page <= cfg_data;
        else if (preg_hit[b])  r.page <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                     blk <= '0;
    else if (cfg_we && int'(cfg_idx) == BLK_IDX)    blk <= cfg_data[BLK_W-1:0];
  end
endmodule

// File: rtl/bankmap_decode.sv
`timescale 1ns/1ps
module bankmap_decode
  import bankmap_pkg::*;
#(
  parameter int PHYS_W = 23
) (
  input  bank_cfg_t          cfg,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         blk,
  output logic               hit,
  output logic [PHYS_W-1:0]  phys
);
  assign hit  = covers(cpu_addr, cfg.base, cfg.mode);
  assign phys = PHYS_W'(phys_calc(cpu_addr, cfg, blk));
endmodule

// File: rtl/bankmap_prio.sv
`timescale 1ns/1ps
module bankmap_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/bankmap_top.sv
`timescale 1ns/1ps
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int PHYS_W = 23,
  localparam int IDX_W = $clog2(NBANKS * CFG_FIELDS + 1),
  localparam int BLK_W = PHYS_W - 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_data,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic              mem_sel,
  output logic              mem_ram,
  output logic              mem_we,
  output logic [PHYS_W-1:0] mem_addr
);
  bank_cfg_t          cfg [NBANKS];
  logic [NBANKS-1:0]  preg_hit;
  logic [BLK_W-1:0]   blk;
  logic [NBANKS-1:0]  hit_vec, win_vec, bank_en, bank_wen;
  logic [PHYS_W-1:0]  phys [NBANKS];
  logic [7:0]         page_first;
  logic               sel_wen;

  bankmap_regs #(.NBANKS(NBANKS), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cpu_wr(cpu_wr), .addr_hi(cpu_addr[15:8]), .cpu_wdata(cpu_wdata),
    .cfg(cfg), .preg_hit(preg_hit), .blk(blk)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_dec
    bankmap_decode #(.PHYS_W(PHYS_W)) u_dec (
      .cfg(cfg[b]), .cpu_addr(cpu_addr), .blk(8'(blk)),
      .hit(hit_vec[b]), .phys(phys[b])
    );
    assign bank_en[b]  = win_ok(cfg[b].mode);
    assign bank_wen[b] = cfg[b].mode[M_WEN];
  end

  bankmap_prio #(.N(NBANKS)) u_prio (.req(hit_vec), .grant(win_vec), .any(mem_sel));

  always_comb begin
    mem_addr = '0;
    mem_ram  = 1'b0;
    sel_wen  = 1'b0;
    for (int b = 0; b < NBANKS; b++) begin
      if (win_vec[b]) begin
        mem_addr = mem_addr | phys[b];
        mem_ram  = mem_ram | cfg[b].mode[M_RAM];
        sel_wen  = sel_wen | cfg[b].mode[M_WEN];
      end
    end
  end

  assign mem_we     = cpu_wr && mem_sel && sel_wen && ((preg_hit & ~bank_wen) == '0);
  assign page_first = cfg[0].page;
endmodule

// File: rtl/bankmap_checker.sv
`timescale 1ns/1ps
module bankmap_checker #(
  parameter int NBANKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic              mem_sel,
  input logic              mem_we,
  input logic [NBANKS-1:0] win_vec,
  input logic [NBANKS-1:0] bank_en,
  input logic [NBANKS-1:0] bank_wen,
  input logic [NBANKS-1:0] preg_hit,
  input logic [7:0]        page_first
);
  assert_onehot_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));
  assert_sel_tracks_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel == (win_vec != '0));
  assert_win_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec & ~bank_en) == '0);
  assert_we_needs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_sel && cpu_wr && ((win_vec & bank_wen) != '0)));
  assert_preg_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((preg_hit & ~bank_wen) != '0) |-> !mem_we);
  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (preg_hit[0] && !cfg_we) |=> (page_first == $past(cpu_wdata)));
endmodule

bind bankmap_top bankmap_checker #(.NBANKS(NBANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .mem_sel(mem_sel), .mem_we(mem_we), .win_vec(win_vec), .bank_en(bank_en),
  .bank_wen(bank_wen), .preg_hit(preg_hit), .page_first(page_first)
);

// File: tb/bankmap_top_bench.sv
`timescale 1ns/1ps
module bankmap_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [7:0]  cfg_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_sel, mem_ram, mem_we;
  logic [22:0] mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [7:0] sh [25];

  bankmap_top u_bankmap_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .mem_sel(mem_sel), .mem_ram(mem_ram), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  always #5 clk = ~clk;

  function automatic int wsize(input logic [7:0] m);
    return 1 << (int'(m[2:0]) + 9);
  endfunction

  function automatic int win_of(input logic [15:0] a);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] m;
      int base, sz, d, dm;
      m = sh[b*6+3];
      if (!m[3] && m[2:0] >= 3) begin
        sz   = wsize(m);
        base = int'(sh[b*6+5]) * 256;
        d    = (int'(a) - base + 65536) % 65536;
        dm   = (int'(a ^ 16'h8000) - base + 65536) % 65536;
        if (d < sz || (!m[6] && dm < sz)) return b;
      end
    end
    return -1;
  endfunction

  function automatic int exp_addr(input logic [15:0] a);
    int w, sz, d, pg;
    w = win_of(a);
    if (w < 0) return 0;
    sz = wsize(sh[w*6+3]);
    d  = ((int'(a) - int'(sh[w*6+5]) * 256 + 65536) % 65536) % sz;
    pg = int'(sh[w*6+2] & sh[w*6+4]);
    return (int'(sh[24][6:0]) * 65536 + pg * sz + d) % (1 << 23);
  endfunction

  function automatic int exp_we(input logic [15:0] a);
    int w;
    w = win_of(a);
    if (w < 0 || !sh[w*6+3][4]) return 0;
    for (int b = 0; b < 4; b++)
      if (sh[b*6+3][7] && ((a[15:8] & sh[b*6]) == sh[b*6+1]) && !sh[b*6+3][4]) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    sh[idx] = d;
  endtask

  task automatic probe(input logic [15:0] a, input string req);
    int w;
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1;
    w = win_of(a);
    chk({req, " sel R10"}, 32'(mem_sel), 32'(w >= 0));
    chk({req, " addr R6"}, 32'(mem_addr), 32'(exp_addr(a)));
    chk({req, " media R7"}, 32'(mem_ram), (w >= 0) ? 32'(sh[w*6+3][5]) : 32'd0);
    chk({req, " we R8"}, 32'(mem_we), 32'd0);
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = d;
    #1;
    chk({req, " we"}, 32'(mem_we), 32'(exp_we(a)));
    @(negedge clk);
    cpu_wr = 1'b0;
    for (int b = 0; b < 4; b++)
      if (sh[b*6+3][7] && ((a[15:8] & sh[b*6]) == sh[b*6+1])) sh[b*6+2] = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 25; i++) sh[i] = 8'h00;
    sh[0] = 8'hF8; sh[1] = 8'h50; sh[2] = 8'h00; sh[3] = 8'h85; sh[4] = 8'h03; sh[5] = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R5 mirror, R10 no match
    probe(16'h4000, "R1 reset");
    chk("R1 reset addr literal", 32'(mem_addr), 32'h0);
    probe(16'h7FFF, "R1 top of window");
    chk("R1 literal 7FFF", 32'(mem_addr), 32'h3FFF);
    probe(16'hC010, "R5 mirror");
    chk("R5 mirror literal", 32'({mem_sel, mem_addr}), 32'h80_0010);
    probe(16'h8000, "R10 no match");
    chk("R10 idle addr", 32'(mem_addr), 32'h0);

    // R2 page register
    cpu_write(16'h5400, 8'h07, "R2 page write blocked R9");
    probe(16'h4000, "R2 after page");
    chk("R2 page masked literal", 32'(mem_addr), 32'h00C000);
    cpu_write(16'h5800, 8'h01, "R2 non-matching write");
    probe(16'h4000, "R2 unchanged");
    chk("R2 page kept literal", 32'(mem_addr), 32'h00C000);

    // R11 block register
    cfg(24, 8'h05);
    probe(16'h4000, "R11 block");
    chk("R11 literal", 32'(mem_addr), 32'h05C000);

    // R4 disabled windows
    cfg(3, 8'h8D);
    probe(16'h4000, "R4 off bit");
    chk("R4 off bit literal", 32'(mem_sel), 32'd0);
    cfg(3, 8'h82);
    probe(16'h4000, "R4 bad size");
    chk("R4 bad size literal", 32'(mem_sel), 32'd0);
    cfg(3, 8'h85);

    // R10 priority, R7 media
    cfg(6, 8'hF8); cfg(7, 8'h60); cfg(8, 8'h02); cfg(9, 8'hB5); cfg(10, 8'hFF); cfg(11, 8'h40);
    probe(16'h4000, "R10 low wins");
    chk("R10 flash wins literal", 32'(mem_ram), 32'd0);
    cfg(3, 8'h8D);
    probe(16'h4000, "R7 ram window");
    chk("R7 ram literal", 32'({mem_ram, mem_addr}), 32'h80_0000 | 32'h058000);

    // R8 / R9 write permission
    cfg(5, 8'h80); cfg(3, 8'h85);
    cpu_write(16'h5000, 8'h01, "R9 blocked by foreign page reg");
    cpu_write(16'h4800, 8'hAA, "R8 write passes");
    cpu_write(16'h6000, 8'h03, "R9 own writable page reg");
    probe(16'h4000, "R2 second window page");
    chk("R2 window1 literal", 32'(mem_addr), 32'h05C000);
    probe(16'h8004, "R6 window0 page 1");

    // R3 size codes on window 3, others disabled
    cfg(3, 8'h08); cfg(9, 8'h08);
    cfg(20, 8'h00); cfg(22, 8'h00); cfg(23, 8'h20);
    for (int c = 3; c <= 7; c++) begin
      cfg(21, 8'h40 | 8'(c));
      probe(16'h2000, "R3 first byte");
      probe(16'(16'h2000 + (1 << (c + 9)) - 1), "R3 last byte");
      if (c < 7) probe(16'(16'h2000 + (1 << (c + 9))), "R3 past end");
      probe(16'hA000, "R5 mirror off");
    end

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int r;
      r = int'($urandom % 6);
      if (r == 0) begin
        int idx;
        logic [7:0] d;
        idx = int'($urandom % 25);
        d = 8'($urandom);
        if (idx % 6 == 3 && idx < 24) d[7] = ($urandom % 4) != 0;
        if (idx % 6 == 0 && idx < 24) d = 8'hF8 | 8'($urandom % 8);
        cfg(idx, d);
      end else if (r < 4) begin
        probe(16'($urandom), "R6 random");
      end else begin
        cpu_write(16'($urandom), 8'($urandom), "R9 random write");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule